// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a memory with two independent access ports, called left and right, and watches both for a clash. A clash exists when both ports are enabled and present the same address. When it sees one, it grants the location to one port and pulls the other port's active-low busy flag low. It also hands each port a write-permit qualifier that the memory uses in place of the raw write enable. The port that reached the matching condition first keeps the location. When both reach it in the same cycle, left wins.

The arbiter is fully synchronous. It keeps one registered copy of each port's enable and address from the previous cycle, which shows which side arrived late. A small owner register holds a grant for as long as the clash lasts. The busy flags and write permits are computed in the same cycle from the current inputs and that state, so a losing write is blocked in the cycle the clash appears.

For word-width expansion, several copies can run side by side. One copy runs as master and drives the busy decision out. The others run as slaves and take busy in from the master, using it to gate their own writes. This keeps every slice of a wide word agreeing on the winner.

Top module: `dp_contention_arb`

## Requirements
- R1: When the two ports are not both enabled (enable is active high) with equal addresses, both busy outputs are high (inactive).
- R2: In master mode, when one port was enabled at an address in the previous cycle and still holds it, and the other port newly forms a match, the newly arriving port's busy output goes low in that same cycle and the other port's busy output stays high.
- R3: In master mode, when both ports form a match in the same cycle with neither holding it from before, exactly one busy output is low: the right port's (left wins).
- R4: In master mode, once a port has been granted, the other port's busy output stays low on every cycle the match persists, even if the losing request stays unchanged.
- R5: Busy is released in the first cycle in which the addresses differ or either enable is low.
- R6: In slave mode (masterMode = 0), both busy outputs stay high, and each port's busy input (active low) is taken as that port's effective busy.
- R7: Each write-permit output equals that port's write enable AND NOT its effective busy. Effective busy is the port's own busy decision in master mode and its busy input in slave mode.
- R8: While the synchronous active-high reset is asserted, both busy outputs are high. The arbiter's history is cleared, so a match present in the first cycle after reset is treated as a same-cycle tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| masterMode | input | 1 | 1 = master (drive busy), 0 = slave (take busy in) |
| enL | input | 1 | Left port enable, active high |
| weL | input | 1 | Left port write enable, active high |
| addrL | input | 12 | Left port address |
| busyInL_n | input | 1 | Left busy from a master, active low (slave mode) |
| enR | input | 1 | Right port enable, active high |
| weR | input | 1 | Right port write enable, active high |
| addrR | input | 12 | Right port address |
| busyInR_n | input | 1 | Right busy from a master, active low (slave mode) |
| busyOutL_n | output | 1 | Left busy flag, active low |
| wrPermitL | output | 1 | Left qualified write enable |
| busyOutR_n | output | 1 | Right busy flag, active low |
| wrPermitR | output | 1 | Right qualified write enable |

## Verification
The hardest case to reach is the difference between a late arrival and a true tie. It depends on what each port did in the previous cycle, which the ports show only indirectly. The stimulus therefore parks one port on an address for a full cycle before moving the other onto it. It then reverses the order, and separately brings both onto the address from idle in the same cycle, including the first cycle after reset. A grant that must survive a still-pending losing request is reached by holding the clash over several cycles. The clash is then broken by an address change and, in a separate step, by dropping an enable.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // What the datapath observes each cycle.
  typedef struct packed {
    logic match;    // both enabled, equal addresses
    logic steadyL;  // left held same enable+address from last cycle
    logic steadyR;  // right held same enable+address from last cycle
  } arbSense_t;

  // Control decision sent back to the datapath.
  typedef struct packed {
    logic blockL;   // left loses the location
    logic blockR;   // right loses the location
  } arbStrobe_t;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

endpackage

// File: rtl/arb_history.sv
module arb_history #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              steady
);

  logic              prevEn;
  logic [ADDR_W-1:0] prevAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevEn   <= 1'b0;
      prevAddr <= '0;
    end else begin
      prevEn   <= en;
      prevAddr <= addr;
    end
  end

  // The port was already sitting at this address last cycle.
  assign steady = en && prevEn && (addr == prevAddr);

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              masterMode,
  input  logic              enL,
  input  logic              weL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              busyInL_n,
  input  logic              enR,
  input  logic              weR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              busyInR_n,
  input  arbStrobe_t        strobe,
  output arbSense_t         sense,
  output logic              busyOutL_n,
  output logic              busyOutR_n,
  output logic              wrPermitL,
  output logic              wrPermitR
);

  localparam int NPORT = 2;

  logic [NPORT-1:0]             portEn;
  logic [NPORT-1:0][ADDR_W-1:0] portAddr;
  logic [NPORT-1:0]             portSteady;

  assign portEn   = {enR, enL};
  assign portAddr = {addrR, addrL};

  for (genvar p = 0; p < NPORT; p++) begin : g_hist
    arb_history #(.ADDR_W(ADDR_W)) u_hist (
      .clk    (clk),
      .rst    (rst),
      .en     (portEn[p]),
      .addr   (portAddr[p]),
      .steady (portSteady[p])
    );
  end

  always_comb begin
    sense.match   = enL && enR && (addrL == addrR);
    sense.steadyL = portSteady[0];
    sense.steadyR = portSteady[1];
  end

  logic effBusyL, effBusyR;

  always_comb begin
    if (masterMode) begin
      busyOutL_n = ~strobe.blockL;
      busyOutR_n = ~strobe.blockR;
      effBusyL   = strobe.blockL;
      effBusyR   = strobe.blockR;
    end else begin
      busyOutL_n = 1'b1;
      busyOutR_n = 1'b1;
      effBusyL   = ~busyInL_n;
      effBusyR   = ~busyInR_n;
    end
    wrPermitL = weL && !effBusyL;
    wrPermitR = weR && !effBusyR;
  end

endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  arbSense_t  sense,
  output arbStrobe_t strobe
);

  owner_e owner, ownerNext;

  always_comb begin
    if (rst || !sense.match) begin
      ownerNext = OWN_NONE;
    end else if (owner != OWN_NONE) begin
      ownerNext = owner;                 // grant held while clash lasts
    end else if (sense.steadyR && !sense.steadyL) begin
      ownerNext = OWN_RIGHT;             // right was there first
    end else begin
      ownerNext = OWN_LEFT;              // left first, or a tie
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owner <= OWN_NONE;
    else     owner <= ownerNext;
  end

  always_comb begin
    strobe.blockL = (ownerNext == OWN_RIGHT);
    strobe.blockR = (ownerNext == OWN_LEFT);
  end

endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb
  import arb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              masterMode,
  input  logic              enL,
  input  logic              weL,
  input  logic [ADDR_W-1:0] addrL,
  input  logic              busyInL_n,
  input  logic              enR,
  input  logic              weR,
  input  logic [ADDR_W-1:0] addrR,
  input  logic              busyInR_n,
  output logic              busyOutL_n,
  output logic              wrPermitL,
  output logic              busyOutR_n,
  output logic              wrPermitR
);

  arbSense_t  sense;
  arbStrobe_t strobe;

  arb_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .masterMode (masterMode),
    .enL        (enL),
    .weL        (weL),
    .addrL      (addrL),
    .busyInL_n  (busyInL_n),
    .enR        (enR),
    .weR        (weR),
    .addrR      (addrR),
    .busyInR_n  (busyInR_n),
    .strobe     (strobe),
    .sense      (sense),
    .busyOutL_n (busyOutL_n),
    .busyOutR_n (busyOutR_n),
    .wrPermitL  (wrPermitL),
    .wrPermitR  (wrPermitR)
  );

  arb_control u_ctl (
    .clk    (clk),
    .rst    (rst),
    .sense  (sense),
    .strobe (strobe)
  );

endmodule

// File: rtl/dp_contention_arb_chk.sv
module dp_contention_arb_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              masterMode,
  input logic              enL,
  input logic              weL,
  input logic [ADDR_W-1:0] addrL,
  input logic              busyInL_n,
  input logic              enR,
  input logic              weR,
  input logic [ADDR_W-1:0] addrR,
  input logic              busyInR_n,
  input logic              busyOutL_n,
  input logic              wrPermitL,
  input logic              busyOutR_n,
  input logic              wrPermitR
);

  logic clash;
  assign clash = enL && enR && (addrL == addrR);

  // R1
  a_r1_no_clash_no_busy: assert property (@(posedge clk) disable iff (rst)
    !clash |-> (busyOutL_n && busyOutR_n));

  // R3: master clash flags exactly one port
  a_r3_one_loser: assert property (@(posedge clk) disable iff (rst)
    (masterMode && clash) |-> (busyOutL_n ^ busyOutR_n));

  // R2: left arrives after right was parked
  a_r2_late_left_busy: assert property (@(posedge clk) disable iff (rst)
    (masterMode && clash && $past(!rst) && $past(enR) && !$past(enL)
     && ($past(addrR) == addrR)) |-> (!busyOutL_n && busyOutR_n));

  // R4: grant holds while the clash persists
  a_r4_grant_held: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && masterMode && $past(masterMode) && $past(clash) && clash
     && !$past(busyOutR_n)) |-> !busyOutR_n);

  // R6
  a_r6_slave_outputs_idle: assert property (@(posedge clk) disable iff (rst)
    !masterMode |-> (busyOutL_n && busyOutR_n));

  // R7: slave busy input blocks writes
  a_r7_slave_gate: assert property (@(posedge clk) disable iff (rst)
    (!masterMode && (!busyInL_n || !weL)) |-> !wrPermitL);

  // R7: master permit follows own busy flag
  a_r7_master_gate: assert property (@(posedge clk) disable iff (rst)
    masterMode |-> (wrPermitR == (weR && busyOutR_n)));

  // R8
  a_r8_reset_idle: assert property (@(posedge clk)
    rst |-> (busyOutL_n && busyOutR_n));

endmodule

bind dp_contention_arb dp_contention_arb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_dp_contention_arb.sv
module sim_dp_contention_arb;

  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          masterMode = 1'b1;
  logic          enL = 1'b0, weL = 1'b0, busyInL_n = 1'b1;
  logic          enR = 1'b0, weR = 1'b0, busyInR_n = 1'b1;
  logic [AW-1:0] addrL = '0, addrR = '0;
  logic          busyOutL_n, wrPermitL, busyOutR_n, wrPermitR;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dp_contention_arb #(.ADDR_W(AW)) u0 (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic setL(input logic e, input logic w, input logic [AW-1:0] a);
    enL = e; weL = w; addrL = a;
  endtask

  task automatic setR(input logic e, input logic w, input logic [AW-1:0] a);
    enR = e; weR = w; addrR = a;
  endtask

  // Advance to the next falling edge (one rising edge passes).
  task automatic nextCyc();
    @(negedge clk);
  endtask

  task automatic idle();
    setL(0, 0, '0); setR(0, 0, '0);
    nextCyc();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    setL(1, 0, 12'h003); setR(1, 0, 12'h003);
    #2;
    chk("R8 busyL in reset", busyOutL_n, 1'b1);
    chk("R8 busyR in reset", busyOutR_n, 1'b1);
    nextCyc();
    rst = 1'b0;
    #2;
    chk("R8 first cycle tie busyR", busyOutR_n, 1'b0);
    chk("R8 first cycle tie busyL", busyOutL_n, 1'b1);
    nextCyc();
    idle();
  endtask

  task automatic t_noMatch();
    setL(1, 1, 12'h010); setR(1, 1, 12'h011);
    #2;
    chk("R1 diff addr busyL", busyOutL_n, 1'b1);
    chk("R1 diff addr busyR", busyOutR_n, 1'b1);
    chk("R7 no clash permitL", wrPermitL, 1'b1);
    nextCyc();
    setL(0, 1, 12'h011);
    #2;
    chk("R1 one disabled busyR", busyOutR_n, 1'b1);
    chk("R1 one disabled busyL", busyOutL_n, 1'b1);
    nextCyc();
    idle();
  endtask

  task automatic t_lateRightHold();
    setL(1, 0, 12'h005);
    nextCyc();
    setR(1, 1, 12'h005);
    #2;
    chk("R2 late right busyR", busyOutR_n, 1'b0);
    chk("R2 late right busyL", busyOutL_n, 1'b1);
    chk("R7 loser permitR", wrPermitR, 1'b0);
    weL = 1'b1;
    #1;
    chk("R7 winner permitL", wrPermitL, 1'b1);
    for (int i = 0; i < 3; i++) begin
      nextCyc();
      #2;
      chk("R4 grant held busyR", busyOutR_n, 1'b0);
    end
    nextCyc();
    addrL = 12'h006;
    #2;
    chk("R5 addr change busyR", busyOutR_n, 1'b1);
    chk("R7 released permitR", wrPermitR, 1'b1);
    nextCyc();
    addrL = 12'h005;
    #2;
    chk("R2 left returns late busyL", busyOutL_n, 1'b0);
    chk("R2 left returns late busyR", busyOutR_n, 1'b1);
    nextCyc();
    enR = 1'b0;
    #2;
    chk("R5 enable drop busyL", busyOutL_n, 1'b1);
    nextCyc();
    idle();
  endtask

  task automatic t_lateLeft();
    setR(1, 0, 12'h800);
    nextCyc();
    setL(1, 1, 12'h800);
    #2;
    chk("R2 late left busyL", busyOutL_n, 1'b0);
    chk("R2 late left busyR", busyOutR_n, 1'b1);
    chk("R7 late left permitL", wrPermitL, 1'b0);
    nextCyc();
    idle();
  endtask

  task automatic t_tie();
    setL(1, 1, 12'hFFF); setR(1, 1, 12'hFFF);
    #2;
    chk("R3 tie busyR", busyOutR_n, 1'b0);
    chk("R3 tie busyL", busyOutL_n, 1'b1);
    chk("R3 tie permitL", wrPermitL, 1'b1);
    chk("R3 tie permitR", wrPermitR, 1'b0);
    nextCyc();
    #2;
    chk("R4 tie grant held", busyOutR_n, 1'b0);
    nextCyc();
    idle();
  endtask

  task automatic t_slave();
    masterMode = 1'b0;
    setL(1, 1, 12'h0AA); setR(1, 1, 12'h0AA);
    busyInL_n = 1'b1; busyInR_n = 1'b0;
    #2;
    chk("R6 slave busyOutL", busyOutL_n, 1'b1);
    chk("R6 slave busyOutR", busyOutR_n, 1'b1);
    chk("R6 slave busy input blocks permitR", wrPermitR, 1'b0);
    chk("R7 slave permitL", wrPermitL, 1'b1);
    nextCyc();
    busyInR_n = 1'b1; busyInL_n = 1'b0;
    setR(1, 1, 12'h0AB);
    #2;
    chk("R6 slave permitR freed", wrPermitR, 1'b1);
    chk("R6 slave input blocks permitL", wrPermitL, 1'b0);
    nextCyc();
    busyInL_n = 1'b1;
    masterMode = 1'b1;
    idle();
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_noMatch();
    t_lateRightHold();
    t_lateLeft();
    t_tie();
    t_slave();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule